// File: doc/BRIEF.md
# SATA Host-to-Device Command Frame Assembler

This block turns one storage command request into the 20-byte register frame a SATA host sends to a drive to start a command. It then streams the frame as five 32-bit words over a valid/ready handshake toward the link layer. A request carries a 3-bit command class, a 48-bit block address, a 16-bit block count, a 5-bit queue tag and a 16-bit PIO byte-count limit. The class selects the ATA opcode and decides which fields land in which byte positions.

The block holds one request at a time. A request is taken in a cycle where `req_valid` is high and `busy` is low. From the next cycle `busy` stays high until the consumer takes the fifth word. A request that names an undefined class is dropped: it produces no words and raises a single-cycle error flag.

Top module: `sata_cmd_frame_tx`

## Requirements
- R1: Word 0 of every frame carries 0x27 in byte 0, and byte 1 has bit 7 set with its other bits zero.
- R2: Byte 2 carries the opcode chosen by `req_class`: 0 identify → 0xEC, 1 DMA read extended → 0x25, 2 DMA write extended → 0x35, 3 queued read → 0x60, 4 queued write → 0x61, 5 flush cache extended → 0xEA, 6 packet → 0xA0.
- R3: For classes 1 to 4, address bits 23:0 fill bytes 4, 5, 6 and bits 47:24 fill bytes 8, 9, 10, least significant byte first in each group. Byte 7 is 0x40 for these classes and 0x00 for every other class.
- R4: For classes 1 and 2, the block count fills byte 12 (low) and byte 13 (high).
- R5: For classes 3 and 4, the block count fills byte 3 (low) and byte 11 (high), and the tag fills byte 12 bits 7:3.
- R6: For class 6, the PIO byte-count limit fills byte 5 (low) and byte 6 (high).
- R7: Every byte that R1 to R6 do not assign is zero. This means request fields that the selected class does not use have no effect on the frame.
- R8: A frame is exactly five words, and word n holds bytes 4n..4n+3 with byte 4n in bits 7:0. `out_last` is high on word 4 only.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values into the next cycle.
- R10: An accepted request raises `busy` and `out_valid` in the next cycle. `busy` falls in the cycle after word 4 is taken. `req_valid` has no effect while `busy` is high.
- R11: A request with class 7 produces no words, leaves `busy` low, and makes `bad_class` high for exactly the one cycle after it is presented.
- R12: During reset and in the cycle after it, `busy`, `out_valid` and `bad_class` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_class | input | 3 | Command class (encoding in R2, 7 undefined) |
| req_lba | input | 48 | Starting block address |
| req_count | input | 16 | Block count |
| req_tag | input | 5 | Queue tag for queued commands |
| req_byte_limit | input | 16 | PIO byte-count limit for packet commands |
| busy | output | 1 | Frame in progress, requests ignored |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word, lowest frame byte in bits 7:0 |
| out_last | output | 1 | Marks the fifth word |
| out_ready | input | 1 | Consumer takes the word |
| bad_class | output | 1 | One-cycle pulse for an undefined class |

## Verification
A corrupted word index shows up at once as a word out of order or a missing or early `out_last`. A wrong stored frame is visible in the first word that does not match, within five handshakes of acceptance. A stuck `busy` or valid state appears as an extra word or a dropped request, which the scoreboard reports when its queue underflows or fails to drain. Stalls from `out_ready` are varied across three patterns, so a word that changes or advances while stalled is caught on the next cycle.

// File: rtl/sata_cmd_frame_pkg.sv
// Package: shared command class encoding and frame constants for the
// command frame assembler. Assumes the frame layout is fixed at 20 bytes.
package sata_cmd_frame_pkg;

    localparam int FRAME_BYTES = 20;
    localparam logic [7:0] FRAME_TYPE_H2D = 8'h27;
    localparam logic [7:0] UPDATE_FLAG    = 8'h80;
    localparam logic [7:0] LBA_MODE_BYTE  = 8'h40;

    typedef enum logic [2:0] {
        CLS_IDENTIFY = 3'd0,
        CLS_RD_EXT   = 3'd1,
        CLS_WR_EXT   = 3'd2,
        CLS_Q_RD     = 3'd3,
        CLS_Q_WR     = 3'd4,
        CLS_FLUSH    = 3'd5,
        CLS_PACKET   = 3'd6,
        CLS_UNDEF    = 3'd7
    } cmd_class_e;

    // Map a command class to its ATA opcode (zero for the undefined class).
    function automatic logic [7:0] class_opcode(input cmd_class_e c);
        case (c)
            CLS_IDENTIFY: class_opcode = 8'hEC;
            CLS_RD_EXT:   class_opcode = 8'h25;
            CLS_WR_EXT:   class_opcode = 8'h35;
            CLS_Q_RD:     class_opcode = 8'h60;
            CLS_Q_WR:     class_opcode = 8'h61;
            CLS_FLUSH:    class_opcode = 8'hEA;
            CLS_PACKET:   class_opcode = 8'hA0;
            default:      class_opcode = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cmd_frame_encode.sv
// Module: combinational encoder from request fields to a flat frame image.
// Byte i of the frame sits at bits [8i+7:8i]. Assumes the caller decides
// when to capture the result; cls_ok is low for the undefined class.
module cmd_frame_encode
    import sata_cmd_frame_pkg::*;
#(
    parameter int LBA_W   = 48,
    parameter int COUNT_W = 16,
    parameter int TAG_W   = 5,
    localparam int FRAME_W = FRAME_BYTES * 8
) (
    input  logic [2:0]         cls,
    input  logic [LBA_W-1:0]   lba,
    input  logic [COUNT_W-1:0] count,
    input  logic [TAG_W-1:0]   tag,
    input  logic [15:0]        byte_limit,
    output logic [FRAME_W-1:0] frame,
    output logic               cls_ok
);

    logic [7:0] fb [FRAME_BYTES];
    cmd_class_e c;

    assign c = cmd_class_e'(cls);

    // Place each field in its byte slot according to the command class.
    always_comb begin
        for (int i = 0; i < FRAME_BYTES; i++) fb[i] = 8'h00;
        fb[0]  = FRAME_TYPE_H2D;
        fb[1]  = UPDATE_FLAG;
        fb[2]  = class_opcode(c);
        cls_ok = (c != CLS_UNDEF);
        case (c)
            CLS_RD_EXT, CLS_WR_EXT, CLS_Q_RD, CLS_Q_WR: begin
                fb[4]  = lba[7:0];
                fb[5]  = lba[15:8];
                fb[6]  = lba[23:16];
                fb[7]  = LBA_MODE_BYTE;
                fb[8]  = lba[31:24];
                fb[9]  = lba[39:32];
                fb[10] = lba[47:40];
                if (c == CLS_Q_RD || c == CLS_Q_WR) begin
                    fb[3]  = count[7:0];
                    fb[11] = count[15:8];
                    fb[12] = {tag, 3'b000};
                end else begin
                    fb[12] = count[7:0];
                    fb[13] = count[15:8];
                end
            end
            CLS_PACKET: begin
                fb[5] = byte_limit[7:0];
                fb[6] = byte_limit[15:8];
            end
            CLS_UNDEF: begin
                fb[0] = 8'h00;
                fb[1] = 8'h00;
            end
            default: ;
        endcase
    end

    // Flatten the byte array into the frame vector.
    always_comb begin
        for (int i = 0; i < FRAME_BYTES; i++) frame[i*8 +: 8] = fb[i];
    end

endmodule

// File: rtl/frame_word_sender.sv
// Module: holds one captured frame and presents it word by word on a
// valid/ready interface. Assumes load is only raised while not active.
module frame_word_sender #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 5,
    localparam int FRAME_W = WORD_W * N_WORDS,
    localparam int IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               active,
    output logic [WORD_W-1:0]  word,
    output logic               last,
    input  logic               take
);

    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;
    logic               active_q;
    logic               at_end;

    assign at_end = (idx_q == IDX_W'(N_WORDS - 1));

    // Capture a frame on load, step the word index on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= '0;
            idx_q    <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            frame_q  <= frame_in;
            idx_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q && take) begin
            if (at_end) begin
                idx_q    <= '0;
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign active = active_q;
    assign word   = frame_q[idx_q*WORD_W +: WORD_W];
    assign last   = active_q && at_end;

endmodule

// File: rtl/sata_cmd_frame_tx.sv
// Module: top of the command frame assembler. Accepts one request when
// idle, encodes it, and streams the frame out. Undefined classes are
// dropped with a one-cycle error pulse. Assumes a synchronous low reset.
module sata_cmd_frame_tx
    import sata_cmd_frame_pkg::*;
#(
    parameter int LBA_W   = 48,
    parameter int COUNT_W = 16,
    parameter int TAG_W   = 5,
    parameter int WORD_W  = 32,
    localparam int N_WORDS = (FRAME_BYTES * 8) / WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_class,
    input  logic [LBA_W-1:0]   req_lba,
    input  logic [COUNT_W-1:0] req_count,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [15:0]        req_byte_limit,
    output logic               busy,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_last,
    input  logic               out_ready,
    output logic               bad_class
);

    logic [FRAME_BYTES*8-1:0] frame;
    logic                     cls_ok;
    logic                     accept;
    logic                     sending;
    logic                     bad_q;

    assign accept = req_valid && !sending;

    cmd_frame_encode #(
        .LBA_W   (LBA_W),
        .COUNT_W (COUNT_W),
        .TAG_W   (TAG_W)
    ) u_encode (
        .cls        (req_class),
        .lba        (req_lba),
        .count      (req_count),
        .tag        (req_tag),
        .byte_limit (req_byte_limit),
        .frame      (frame),
        .cls_ok     (cls_ok)
    );

    frame_word_sender #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS)
    ) u_sender (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && cls_ok),
        .frame_in (frame),
        .active   (sending),
        .word     (out_data),
        .last     (out_last),
        .take     (out_ready)
    );

    // Register the error pulse for a dropped undefined-class request.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_q <= 1'b0;
        else        bad_q <= accept && !cls_ok;
    end

    assign busy      = sending;
    assign out_valid = sending;
    assign bad_class = bad_q;

endmodule

// File: rtl/sata_cmd_frame_tx_chk.sv
// Module: protocol checker for the command frame assembler, bound to the
// top. Tracks its own word count to check framing and the first word.
module sata_cmd_frame_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_class,
    input logic        busy,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic        out_ready,
    input logic        bad_class
);

    logic [2:0] wcnt;

    // Count words taken within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wcnt <= '0;
        else if (out_valid && out_ready && out_last) wcnt <= '0;
        else if (out_valid && out_ready)           wcnt <= wcnt + 1'b1;
    end

    assert_word0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wcnt == 3'd0) |-> (out_data[15:0] == 16'h8027));

    assert_last_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (wcnt == 3'd4)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !busy);

    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_class != 3'd7) |=> (busy && out_valid));

    assert_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_class == 3'd7) |=> (bad_class && !out_valid));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_class && !(req_valid && !busy && req_class == 3'd7)) |=> !bad_class);

    assert_reset_R12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !out_valid && !bad_class));

endmodule

bind sata_cmd_frame_tx sata_cmd_frame_tx_chk u_chk (.*);

// File: tb/tb_sata_cmd_frame_tx.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected words, the monitor pops and
// compares them as the design hands them over.
module tb_sata_cmd_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_class = 3'd0;
    logic [47:0] req_lba = '0;
    logic [15:0] req_count = '0;
    logic [4:0]  req_tag = '0;
    logic [15:0] req_byte_limit = '0;
    logic        busy, out_valid, out_last, bad_class;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;

    int n_checks = 0;
    int n_fail = 0;
    int rmode = 0;
    bit done = 0;
    bit mon_on = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    sata_cmd_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_lba(req_lba), .req_count(req_count), .req_tag(req_tag),
        .req_byte_limit(req_byte_limit), .busy(busy), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .bad_class(bad_class)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected frame built from the byte rules R1..R7, packed per R8.
    task automatic push_expected(input logic [2:0] cls, input logic [47:0] lba,
                                 input logic [15:0] cnt, input logic [4:0] tg,
                                 input logic [15:0] lim, input string req);
        logic [7:0] b [20];
        for (int i = 0; i < 20; i++) b[i] = 8'h00;
        b[0] = 8'h27; b[1] = 8'h80;
        case (cls)
            3'd0: b[2] = 8'hEC;
            3'd1: b[2] = 8'h25;
            3'd2: b[2] = 8'h35;
            3'd3: b[2] = 8'h60;
            3'd4: b[2] = 8'h61;
            3'd5: b[2] = 8'hEA;
            default: b[2] = 8'hA0;
        endcase
        if (cls >= 3'd1 && cls <= 3'd4) begin
            for (int k = 0; k < 3; k++) begin
                b[4+k] = lba[8*k +: 8];
                b[8+k] = lba[24+8*k +: 8];
            end
            b[7] = 8'h40;
        end
        if (cls == 3'd1 || cls == 3'd2) begin
            b[12] = cnt[7:0]; b[13] = cnt[15:8];
        end
        if (cls == 3'd3 || cls == 3'd4) begin
            b[3] = cnt[7:0]; b[11] = cnt[15:8]; b[12] = {tg, 3'b000};
        end
        if (cls == 3'd6) begin
            b[5] = lim[7:0]; b[6] = lim[15:8];
        end
        for (int w = 0; w < 5; w++) begin
            exp_q.push_back({(w == 4), b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
            tag_q.push_back(req);
        end
    endtask

    // Driver: present one request at a negedge once idle, then check R10/R11.
    task automatic send(input logic [2:0] cls, input logic [47:0] lba,
                        input logic [15:0] cnt, input logic [4:0] tg,
                        input logic [15:0] lim, input string req);
        while (busy) @(negedge clk);
        if (cls != 3'd7) push_expected(cls, lba, cnt, tg, lim, req);
        req_valid = 1'b1; req_class = cls; req_lba = lba;
        req_count = cnt; req_tag = tg; req_byte_limit = lim;
        @(negedge clk);
        req_valid = 1'b0;
        if (cls == 3'd7) begin
            check(bad_class && !busy && !out_valid, "R11 pulse",
                  {61'd0, bad_class, busy, out_valid}, 64'h4);
            @(negedge clk);
            check(!bad_class && !busy, "R11 single cycle",
                  {62'd0, bad_class, busy}, 64'h0);
        end else begin
            check(busy && out_valid, "R10 busy after accept",
                  {62'd0, busy, out_valid}, 64'h3);
            // R10: a request while busy is ignored (scoreboard sees no extra frame)
            req_valid = 1'b1; req_class = 3'd1; req_lba = 48'h123456789ABC;
            req_count = 16'h7777;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: set ready, then compare any word handed over at the next edge.
    initial begin
        int cyc = 0;
        logic        prev_stall = 1'b0;
        logic [32:0] prev_word = '0;
        logic [32:0] e;
        string       t;
        forever begin
            @(negedge clk);
            cyc++;
            case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                default: out_ready = (cyc % 3 == 0);
            endcase
            #0.5;
            if (mon_on) begin
                if (prev_stall)
                    check(out_valid && {out_last, out_data} == prev_word, "R9 hold",
                          {31'd0, out_last, out_data}, {31'd0, prev_word});
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10 unexpected word", {31'd0, out_last, out_data}, 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_last, out_data} == e, t,
                              {31'd0, out_last, out_data}, {31'd0, e});
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_word  = {out_last, out_data};
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !out_valid && !bad_class, "R12 reset state",
              {61'd0, busy, out_valid, bad_class}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid && !bad_class, "R12 after reset",
              {61'd0, busy, out_valid, bad_class}, 64'd0);
        mon_on = 1;
        for (int m = 0; m < 3; m++) begin
            rmode = m;
            // R7: identify ignores address and count
            send(3'd0, 48'hDEADBEEFCAFE, 16'h5555, 5'd9, 16'h1111, "R7 identify R1 R2");
            send(3'd1, 48'hA1B2C3D4E5F6, 16'h1234, 5'd3, 16'h2222, "R3 R4 dma read");
            send(3'd2, 48'hFFFFFFFFFFFF, 16'hFFFF, 5'd0, 16'h0000, "R3 R4 dma write max");
            send(3'd3, 48'h000000000001, 16'h0100, 5'd31, 16'h3333, "R5 queued read tag31");
            send(3'd4, 48'h800000000000, 16'h00FF, 5'd5, 16'h4444, "R5 queued write");
            send(3'd5, 48'h111111111111, 16'h9999, 5'd7, 16'h5555, "R2 R7 flush");
            send(3'd6, 48'h222222222222, 16'h8888, 5'd1, 16'hBEEF, "R6 packet");
            send(3'd7, 48'h333333333333, 16'h1, 5'd2, 16'h6666, "R11 undefined");
        end
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && !busy, "R8 frames drained",
              64'(exp_q.size()), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule